// File: doc/BRIEF.md
# Watchdog Timer with Keyed Feed Sequence

This block is a watchdog peripheral on a simple 32-bit register bus. Software sets a timeout constant and turns on the enable bit. The first correct two-word feed then starts a down-counter, which steps once per four pulses of a watchdog tick. Each later correct feed reloads the counter from the constant. If the counter runs out, the block expires: it latches a timeout flag and an interrupt flag, and it can request a system reset.

Each feed is guarded by a key pair. Software first writes 0xAA to the feed register and then 0x55. After a completed feed, the next feed write must start a new pair. If it carries any other value, the block expires at once. Once set, the enable bit cannot be cleared by software; only the block's own reset stops the watchdog. After expiry the counter reads zero and further feeds are ignored until the block is reset.

Top module: `wdog_seq`

## Requirements
- R1: Registers sit at byte addresses 0x0 (mode), 0x4 (timeout constant), 0x8 (feed, reads 0) and 0xC (current count, read-only). The mode register holds enable at bit 0, reset-on-expiry at bit 1, timeout flag at bit 2 and interrupt flag at bit 3. After reset, mode reads 0 and the constant reads 0xFF.
- R2: A constant written below 0xFF is stored as 0xFF. Any other written value is stored as written.
- R3: A mode write with bit 0 set turns the enable on. No later mode write clears it; only the block reset does. Bit 1 takes the written value on every mode write.
- R4: Until the first valid feed made while enabled, the count register follows the constant and does not count. Feed writes made while disabled have no effect.
- R5: A feed register write of 0xAA followed by a feed register write of 0x55 reloads the counter with the constant and starts it.
- R6: While running, the counter decrements once per four cycles in which wd_tick_i is high. With the tick low, it holds.
- R7: With constant C, expiry occurs (C+1)*4 ticks after a valid feed. On expiry the timeout and interrupt flags set, irq_o goes high and the count reads 0.
- R8: Any mode write clears the timeout flag. Software cannot clear the interrupt flag or irq_o.
- R9: On expiry, rst_req_o goes high if bit 1 is set, and it stays high until the block reset. With bit 1 clear, rst_req_o stays low.
- R10: A feed write of any value other than 0xAA, made as the first feed write after a valid feed, causes expiry in the same cycle.
- R11: If 0xAA is followed by a feed write other than 0x55, the sequence is abandoned: there is no reload and no expiry. A following feed write of any value other than 0xAA is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and logic clock |
| rst_ni | input | 1 | Active-low asynchronous block reset |
| wd_tick_i | input | 1 | Watchdog clock enable pulse |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write strobe, qualified by select |
| bus_addr_i | input | 4 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 1 | Interrupt, mirrors the interrupt flag |
| rst_req_o | output | 1 | Latched system reset request |

## Verification
The assertions check several properties on every cycle: the enable, interrupt and reset-request outputs never fall, the stored constant never drops below its minimum, the counter reads zero once expired and tracks the constant while idle, and an expiry event (including a bad feed) is followed by the interrupt and, with reset mode on, by the reset request. Other behaviour needs the bench's scenarios. These cover the exact expiry cycle for a given constant, the four-tick step and the hold with the tick low, the abandoned key pair leaving the count untouched, the ignored stray write after an abandon, and the feeds ignored while disabled.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFF_MODE  = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_CONST = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_FEED  = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_CNT   = 4'hC;

  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_RST  = 1;
  localparam int unsigned BIT_TOF  = 2;
  localparam int unsigned BIT_INT  = 3;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h0000_00AA;
  localparam logic [DATA_W-1:0] KEY_SECOND = 32'h0000_0055;
  localparam logic [DATA_W-1:0] CONST_MIN  = 32'h0000_00FF;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_HALF = 2'd1,
    FS_POST = 2'd2
  } feed_st_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          expire_evt_i,
  input  logic [DW-1:0] cnt_i,
  output logic          en_o,
  output logic          rst_en_o,
  output logic          int_o,
  output logic [DW-1:0] const_o,
  output logic          feed_wr_o,
  output logic [DW-1:0] rdata_o
);
  logic wr, mode_wr, const_wr;
  logic en_q, rst_en_q, tof_q, int_q;
  logic [DW-1:0] const_q;

  assign wr        = sel_i & we_i;
  assign mode_wr   = wr && (addr_i == OFF_MODE);
  assign const_wr  = wr && (addr_i == OFF_CONST);
  assign feed_wr_o = wr && (addr_i == OFF_FEED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      rst_en_q <= 1'b0;
      tof_q    <= 1'b0;
      int_q    <= 1'b0;
      const_q  <= CONST_MIN;
    end else begin
      if (mode_wr) begin
        en_q     <= en_q | wdata_i[BIT_EN];
        rst_en_q <= wdata_i[BIT_RST];
      end
      // set beats clear
      if (expire_evt_i)  tof_q <= 1'b1;
      else if (mode_wr)  tof_q <= 1'b0;
      if (expire_evt_i)  int_q <= 1'b1;
      if (const_wr)      const_q <= (wdata_i < CONST_MIN) ? CONST_MIN : wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_MODE: begin
        rdata_o[BIT_EN]  = en_q;
        rdata_o[BIT_RST] = rst_en_q;
        rdata_o[BIT_TOF] = tof_q;
        rdata_o[BIT_INT] = int_q;
      end
      OFF_CONST: rdata_o = const_q;
      OFF_CNT:   rdata_o = cnt_i;
      default:   rdata_o = '0;
    endcase
  end

  assign en_o     = en_q;
  assign rst_en_o = rst_en_q;
  assign int_o    = int_q;
  assign const_o  = const_q;
endmodule

// File: rtl/wdog_feed.sv
module wdog_feed
  import wdog_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          feed_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          feed_ok_o,
  output logic          feed_bad_o
);
  feed_st_e st_q, st_d;
  logic take;

  assign take = feed_wr_i & active_i;

  always_comb begin
    st_d       = st_q;
    feed_ok_o  = 1'b0;
    feed_bad_o = 1'b0;
    if (take) begin
      unique case (st_q)
        FS_IDLE: if (wdata_i == KEY_FIRST) st_d = FS_HALF;
        FS_HALF: begin
          if (wdata_i == KEY_SECOND) begin
            st_d      = FS_POST;
            feed_ok_o = 1'b1;
          end else begin
            st_d = FS_IDLE;
          end
        end
        FS_POST: begin
          if (wdata_i == KEY_FIRST) begin
            st_d = FS_HALF;
          end else begin
            st_d       = FS_IDLE;
            feed_bad_o = 1'b1;
          end
        end
        default: st_d = FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= FS_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt
  import wdog_pkg::*;
#(
  parameter int unsigned CW       = DATA_W,
  parameter int unsigned TICK_DIV = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          feed_ok_i,
  input  logic          feed_bad_i,
  input  logic [CW-1:0] const_i,
  output logic [CW-1:0] cnt_o,
  output logic          running_o,
  output logic          expired_o,
  output logic          expire_evt_o
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;
  logic run_q, exp_q, step;

  assign step         = run_q && tick_i && (pre_q == P_LAST);
  assign expire_evt_o = !exp_q && (feed_bad_i || (step && cnt_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= CONST_MIN[CW-1:0];
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else if (expire_evt_o) begin
      exp_q <= 1'b1;
      cnt_q <= '0;
    end else if (!exp_q) begin
      if (feed_ok_i) begin
        cnt_q <= const_i;
        pre_q <= '0;
        run_q <= 1'b1;
      end else if (!run_q) begin
        cnt_q <= const_i;
      end else if (tick_i) begin
        if (pre_q == P_LAST) begin
          pre_q <= '0;
          cnt_q <= cnt_q - 1'b1;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign running_o = run_q;
  assign expired_o = exp_q;
endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
  import wdog_pkg::*;
#(
  parameter int unsigned DW       = DATA_W,
  parameter int unsigned AW       = ADDR_W,
  parameter int unsigned TICK_DIV = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wd_tick_i,
  input  logic          bus_sel_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o,
  output logic          rst_req_o
);
  logic en, rst_en, int_f, feed_wr, feed_ok, feed_bad;
  logic running, expired, expire_evt, rst_req_q;
  logic [DW-1:0] const_q, cnt;

  wdog_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(bus_sel_i), .we_i(bus_we_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .expire_evt_i(expire_evt),
    .cnt_i(cnt), .en_o(en), .rst_en_o(rst_en), .int_o(int_f),
    .const_o(const_q), .feed_wr_o(feed_wr), .rdata_o(bus_rdata_o)
  );

  wdog_feed #(.DW(DW)) u_feed (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(en & ~expired),
    .feed_wr_i(feed_wr), .wdata_i(bus_wdata_i),
    .feed_ok_o(feed_ok), .feed_bad_o(feed_bad)
  );

  wdog_cnt #(.CW(DW), .TICK_DIV(TICK_DIV)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(wd_tick_i),
    .feed_ok_i(feed_ok), .feed_bad_i(feed_bad), .const_i(const_q),
    .cnt_o(cnt), .running_o(running), .expired_o(expired),
    .expire_evt_o(expire_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else if (expire_evt && rst_en) rst_req_q <= 1'b1;
  end

  assign rst_req_o = rst_req_q;
  assign irq_o     = int_f;
endmodule

// File: rtl/wdog_seq_chk.sv
module wdog_seq_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en,
  input logic          rst_en,
  input logic          running,
  input logic          expired,
  input logic          expire_evt,
  input logic          feed_bad,
  input logic          irq_o,
  input logic          rst_req_o,
  input logic [DW-1:0] const_q,
  input logic [DW-1:0] cnt
);
  assert_en_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en |=> en);
  assert_const_floor_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    const_q >= DW'(32'hFF));
  assert_idle_tracks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && $past(!running)) |-> cnt == $past(const_q));
  assert_expired_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired |-> cnt == '0);
  assert_irq_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_evt |=> irq_o);
  assert_irq_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> irq_o);
  assert_rst_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_evt && rst_en) |=> rst_req_o);
  assert_rst_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);
  assert_bad_feed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_bad |=> (irq_o && cnt == '0));
endmodule

bind wdog_seq wdog_seq_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en(en), .rst_en(rst_en),
  .running(running), .expired(expired), .expire_evt(expire_evt),
  .feed_bad(feed_bad), .irq_o(irq_o), .rst_req_o(rst_req_o),
  .const_q(const_q), .cnt(cnt)
);

// File: tb/wdog_seq_tb.sv
module wdog_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wd_tick_i = 1'b1;
  logic        bus_sel_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [3:0]  bus_addr_i = 4'h0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o, rst_req_o;

  int total = 0;
  int bad = 0;
  logic [31:0] v;

  always #4 clk_i = ~clk_i;

  wdog_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wd_tick_i(wd_tick_i),
    .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  // {write value, expected stored constant}
  localparam logic [63:0] VEC [6] = '{
    {32'h0000_0000, 32'h0000_00FF},
    {32'h0000_00FE, 32'h0000_00FF},
    {32'h0000_00FF, 32'h0000_00FF},
    {32'h0000_0100, 32'h0000_0100},
    {32'h0001_2345, 32'h0001_2345},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_sel_i = 1'b0; bus_we_i = 1'b0; bus_wdata_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    wait_cyc(2);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic feed();
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'h55);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk_i);
    do_reset();
    // R1 reset state
    rd(4'h0, v); chk("R1 mode reset", v, 32'h0);
    rd(4'h4, v); chk("R1 const reset", v, 32'hFF);
    rd(4'hC, v); chk("R1 count reset", v, 32'hFF);
    rd(4'h8, v); chk("R1 feed reads 0", v, 32'h0);
    chk("R1 irq reset", {31'b0, irq_o}, 32'h0);
    chk("R1 rst_req reset", {31'b0, rst_req_o}, 32'h0);

    // R2 clamp table
    for (int i = 0; i < 6; i++) begin
      wr(4'h4, VEC[i][63:32]);
      rd(4'h4, v); chk("R2 const store", v, VEC[i][31:0]);
    end

    // R4 feed ignored while disabled, count tracks constant
    wr(4'h4, 32'h100);
    feed();
    wait_cyc(8);
    rd(4'hC, v); chk("R4 count follows const, disabled feed ignored", v, 32'h100);

    // R3 enable sticky
    wr(4'h0, 32'h3);
    rd(4'h0, v); chk("R3 enable set", v, 32'h3);
    wr(4'h0, 32'h0);
    rd(4'h0, v); chk("R3 enable not cleared", v, 32'h1);
    wait_cyc(8);
    rd(4'hC, v); chk("R4 enabled but unfed holds", v, 32'h100);
    wr(4'h8, 32'h33);
    chk("R4 stray write before first feed ignored", {31'b0, irq_o}, 32'h0);
    wr(4'h0, 32'h3);

    // R5 / R6 feed and step
    feed();
    rd(4'hC, v); chk("R5 feed loads const", v, 32'h100);
    wait_cyc(3);
    rd(4'hC, v); chk("R6 no step before 4 ticks", v, 32'h100);
    wait_cyc(1);
    rd(4'hC, v); chk("R6 step after 4 ticks", v, 32'hFF);
    wd_tick_i = 1'b0;
    wait_cyc(20);
    rd(4'hC, v); chk("R6 tick low holds", v, 32'hFF);
    wd_tick_i = 1'b1;

    // R11 abandon: feed at edge 0, AA at edge 8, 0x12 at edge 9
    feed();
    wait_cyc(7);
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'h12);
    rd(4'hC, v); chk("R11 abandoned pair no reload", v, 32'hFE);
    chk("R11 abandoned pair no expiry", {31'b0, irq_o}, 32'h0);
    wr(4'h8, 32'h77);
    rd(4'hC, v); chk("R11 stray after abandon ignored", v, 32'hFE);
    chk("R11 stray after abandon no irq", {31'b0, irq_o}, 32'h0);

    // R7 / R9 expiry with C = 0x100: (0x100+1)*4 = 1028 ticks
    feed();
    wait_cyc(1027);
    rd(4'hC, v); chk("R7 count zero before expiry", v, 32'h0);
    chk("R7 no irq one tick early", {31'b0, irq_o}, 32'h0);
    wait_cyc(1);
    rd(4'h0, v); chk("R7 flags set on expiry", v, 32'hF);
    chk("R7 irq on expiry", {31'b0, irq_o}, 32'h1);
    chk("R9 reset request on expiry", {31'b0, rst_req_o}, 32'h1);
    feed();
    rd(4'hC, v); chk("R7 feed after expiry ignored", v, 32'h0);

    // R8 flag clearing
    wr(4'h0, 32'h3);
    rd(4'h0, v); chk("R8 tof cleared, int kept", v, 32'hB);
    chk("R8 irq stays", {31'b0, irq_o}, 32'h1);
    chk("R9 reset request stays", {31'b0, rst_req_o}, 32'h1);

    // R10 bad write right after valid feed
    do_reset();
    chk("R9 reset request cleared by reset", {31'b0, rst_req_o}, 32'h0);
    wr(4'h4, 32'h200);
    wr(4'h0, 32'h3);
    feed();
    rd(4'hC, v); chk("R10 loaded before bad write", v, 32'h200);
    wr(4'h8, 32'h33);
    rd(4'hC, v); chk("R10 count zero after bad write", v, 32'h0);
    chk("R10 irq after bad write", {31'b0, irq_o}, 32'h1);
    chk("R10 reset request after bad write", {31'b0, rst_req_o}, 32'h1);

    // R9 no reset request with reset mode off, minimum constant
    do_reset();
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h1);
    feed();
    wait_cyc(1023);
    chk("R7 min const no irq early", {31'b0, irq_o}, 32'h0);
    wait_cyc(1);
    chk("R7 min const irq at 1024", {31'b0, irq_o}, 32'h1);
    chk("R9 no reset request when off", {31'b0, rst_req_o}, 32'h0);

    finish_run();
  end
endmodule